// File: doc/BRIEF.md
# Interleaved Page-Mode DRAM Controller

This controller connects a 32-bit processor request port to two DRAM banks. The banks share one multiplexed row/column address bus, one row strobe and one data path. Each bank has its own column strobe. Word address bit 0 picks the bank, so consecutive words alternate between the banks. The processor tags every request as sequential or not, which tells the controller whether the request continues the previous run.

A sequential request whose row is already open takes the page-mode path. Only the column address and the column strobe of its bank are driven. If that bank did not strobe in the previous clock, the word completes in the clock it is presented. When sequential runs alternate banks, this gives one word per clock. A non-sequential request, or a sequential one that leaves the open row, runs a full cycle: precharge, row open, then column. A cache line fill of four words therefore costs 3+1+1+1 clocks. An isolated write, presented as non-sequential, always pays the full cycle.

The processor holds its request stable until `rdy` pulses, and may present the next request in the following clock.

Top module: `pm_dram_ctrl`

## Requirements
- R1: While reset is held, `rdy` is 0, `dram_ras_n` is 1 and both column strobes are high.
- R2: Word address bit 0 selects the bank: strobe `dram_cas_n[0]` for even words and `dram_cas_n[1]` for odd words. Address bits [9:1] appear on `dram_ma[8:0]` as the column. Bits [19:10] appear on `dram_ma` as the row during the row-open clock.
- R3: A non-sequential request takes exactly three clocks. Clock one is precharge (`dram_ras_n` high). Clock two is row open (`dram_ras_n` low, row on `dram_ma`). Clock three is the column clock, with one column strobe low and `rdy` high.
- R4: A sequential request to the open row, in the bank that did not strobe in the previous clock, completes with `rdy` in the first clock it is presented.
- R5: A sequential request to the open row, in the bank that strobed in the previous clock, takes two clocks. If that bank strobed earlier, with an idle clock in between, it takes one clock.
- R6: A sequential request takes the three-clock cycle of R3 when no row is open or its row differs from the open row.
- R7: A non-sequential request, read or write, takes three clocks even when its row is already open.
- R8: `rdy` is high for one clock per completed word, never without a request. In that clock, read data equals `dram_rdata`. For a write, `dram_we_n` is low and `dram_wdata` equals `wdata`.
- R9: Between requests the row stays open (`dram_ras_n` low). A four-word line fill, one non-sequential word followed by three sequential words, completes in 6 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid, held until rdy |
| seq | input | 1 | Request continues the previous run |
| we | input | 1 | Write when 1, read when 0 |
| addr | input | 20 | Word address |
| wdata | input | 32 | Write data |
| rdy | output | 1 | Word completed this clock |
| rdata | output | 32 | Read data, valid with rdy |
| dram_ma | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Shared row strobe, active low |
| dram_cas_n | output | 2 | Per-bank column strobes, active low |
| dram_we_n | output | 1 | DRAM write enable, active low |
| dram_wdata | output | 32 | Data to DRAM |
| dram_rdata | input | 32 | Data from DRAM |

## Verification
The result of a request is due in the first, second or third clock after it is presented. The first clock applies to a page hit on the other bank, the second to a page hit on the same bank, and the third to a full cycle. The bench drives each request at a falling edge and samples 1 ns later in every clock. It counts clocks until `rdy` and compares that count with the expected timing class. It also checks the row strobe and the address bus in the precharge and row-open clocks, and the strobe, data and write enable in the `rdy` clock. A DRAM model in the bench latches the row at the row-open edge and returns data built from the row, column and bank. This makes every read value predictable from the address alone.

// File: rtl/pm_dram_ctrl.sv
module pm_dram_ctrl #(
  parameter int COLW = 9,
  parameter int ROWW = 10,
  parameter int DW = 32,
  localparam int AW = ROWW + COLW + 1,
  localparam int MAW = (ROWW > COLW) ? ROWW : COLW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           seq,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic           rdy,
  output logic [DW-1:0]  rdata,
  output logic [MAW-1:0] dram_ma,
  output logic           dram_ras_n,
  output logic [1:0]     dram_cas_n,
  output logic           dram_we_n,
  output logic [DW-1:0]  dram_wdata,
  input  logic [DW-1:0]  dram_rdata
);

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_COL} st_t;

  st_t             st;
  logic [ROWW-1:0] open_row;
  logic            open_v;
  logic [1:0]      cas_last;

  wire             bank = addr[0];
  wire [COLW-1:0]  col  = addr[COLW:1];
  wire [ROWW-1:0]  row  = addr[AW-1:COLW+1];

  wire hit     = seq && open_v && (row == open_row);
  wire start   = (st == ST_IDLE) && req;
  wire miss    = start && !hit;
  wire fast    = start && hit && !cas_last[bank];
  wire col_cyc = fast || (st == ST_COL);

  wire [1:0] cas_sel = col_cyc ? (2'b01 << bank) : 2'b00;

  assign rdy        = col_cyc;
  assign rdata      = dram_rdata;
  assign dram_cas_n = ~cas_sel;
  assign dram_ras_n = !((st == ST_ROW) || (open_v && !miss));
  assign dram_ma    = (st == ST_ROW) ? MAW'(row) : MAW'(col);
  assign dram_we_n  = !(col_cyc && we);
  assign dram_wdata = wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      open_v   <= 1'b0;
      open_row <= '0;
      cas_last <= 2'b00;
    end else begin
      cas_last <= cas_sel;
      case (st)
        ST_IDLE: begin
          if (miss) begin
            open_v <= 1'b0;
            st     <= ST_ROW;
          end else if (start && !fast) begin
            st <= ST_COL;
          end
        end
        ST_ROW: begin
          open_row <= row;
          open_v   <= 1'b1;
          st       <= ST_COL;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: the row opens only after a precharge clock
  a_r3_precharge_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ROW) |-> $past(dram_ras_n));

  // R3: a full cycle ends with rdy in its third clock
  a_r3_ready_third: assert property (@(posedge clk) disable iff (!rst_n)
    miss |-> ##2 rdy);

  // R5: no bank strobes in two consecutive clocks
  for (genvar g = 0; g < 2; g++) begin : g_bank
    a_r5_cas_gap: assert property (@(posedge clk) disable iff (!rst_n)
      !dram_cas_n[g] |-> $past(dram_cas_n[g]));
  end

  // R8: one strobe per completed word
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> ($countones(~dram_cas_n) == 1));

  a_r8_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~dram_cas_n) <= 1);

  // R9: the row is open whenever a word completes
  a_r9_row_open: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> !dram_ras_n);

endmodule

// File: tb/pm_dram_ctrl_test.sv
`timescale 1ns/1ps
module pm_dram_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, seq = 1'b0, we = 1'b0;
  logic [19:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        rdy;
  logic [31:0] rdata;
  logic [9:0]  dram_ma;
  logic        dram_ras_n, dram_we_n;
  logic [1:0]  dram_cas_n;
  logic [31:0] dram_wdata, dram_rdata;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pm_dram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .seq(seq), .we(we), .addr(addr),
    .wdata(wdata), .rdy(rdy), .rdata(rdata), .dram_ma(dram_ma),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
  );

  logic [9:0] row_l = '0;
  logic       ras_prev = 1'b1;
  always @(posedge clk) begin
    if (ras_prev && !dram_ras_n) row_l <= dram_ma;
    ras_prev <= dram_ras_n;
  end
  assign dram_rdata = {12'hD00, row_l, dram_ma[8:0], ~dram_cas_n[1]};

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_acc(input logic [19:0] a, input logic s, input logic w,
                        input int exp_cyc, input string tag);
    int n;
    @(negedge clk);
    req = 1'b1; addr = a; seq = s; we = w; wdata = ~{12'h000, a};
    #1; n = 1;
    if (exp_cyc == 3) chk(dram_ras_n == 1'b1, "R3", "precharge ras_n", 32'(dram_ras_n), 32'd1);
    while (!rdy && n < 16) begin
      @(negedge clk); #1; n++;
      if (exp_cyc == 3 && n == 2)
        chk(!dram_ras_n && dram_ma == a[19:10], "R2", "row address", 32'(dram_ma), 32'(a[19:10]));
    end
    chk(n == exp_cyc, tag, "clocks to rdy", 32'(n), 32'(exp_cyc));
    chk(dram_ma == {1'b0, a[9:1]}, "R2", "column address", 32'(dram_ma), 32'({1'b0, a[9:1]}));
    chk(dram_cas_n == (a[0] ? 2'b01 : 2'b10), "R2", "bank strobe", 32'(dram_cas_n),
        32'(a[0] ? 2'b01 : 2'b10));
    if (w)
      chk(!dram_we_n && dram_wdata == ~{12'h000, a}, "R8", "write data/we_n",
          dram_wdata, ~{12'h000, a});
    else
      chk(dram_we_n && rdata == {12'hD00, a}, "R8", "read data", rdata, {12'hD00, a});
  endtask

  // {addr, seq, we, clocks}
  localparam logic [25:0] VEC [11] = '{
    {20'h00400, 1'b0, 1'b0, 4'd3},
    {20'h00401, 1'b1, 1'b0, 4'd1},
    {20'h00402, 1'b1, 1'b0, 4'd1},
    {20'h00403, 1'b1, 1'b0, 4'd1},
    {20'h00405, 1'b1, 1'b0, 4'd2},
    {20'h00406, 1'b0, 1'b0, 4'd3},
    {20'h00800, 1'b1, 1'b0, 4'd3},
    {20'h00801, 1'b1, 1'b1, 4'd1},
    {20'h00C03, 1'b0, 1'b1, 4'd3},
    {20'hFFFFF, 1'b0, 1'b0, 4'd3},
    {20'hFFFFE, 1'b1, 1'b0, 4'd1}
  };

  function automatic string vtag(input int i);
    case (i)
      0: return "R3";
      1, 10: return "R4";
      2, 3: return "R9";
      4: return "R5";
      5, 8: return "R7";
      6: return "R6";
      7: return "R8";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rdy == 1'b0, "R1", "rdy in reset", 32'(rdy), 32'd0);
    chk(dram_ras_n == 1'b1, "R1", "ras_n in reset", 32'(dram_ras_n), 32'd1);
    chk(dram_cas_n == 2'b11, "R1", "cas_n in reset", 32'(dram_cas_n), 32'd3);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 11; i++)
      do_acc(VEC[i][25:6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), vtag(i));

    @(negedge clk); req = 1'b0; #1;
    chk(rdy == 1'b0, "R8", "rdy after drop", 32'(rdy), 32'd0);
    chk(dram_ras_n == 1'b0, "R9", "row held open", 32'(dram_ras_n), 32'd0);
    chk(dram_cas_n == 2'b11, "R8", "no strobe idle", 32'(dram_cas_n), 32'd3);

    do_acc(20'hFFFFC, 1'b1, 1'b0, 1, "R5");

    @(negedge clk); req = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    do_acc(20'h00010, 1'b1, 1'b0, 3, "R6");
    do_acc(20'h00011, 1'b1, 1'b0, 1, "R4");

    @(negedge clk); req = 1'b0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule